// File: doc/BRIEF.md
# DMA Controller Command, Mask and Request Control

This block holds the controller-wide state of a four-channel DMA engine and decodes the eight controller-level register ports through which software steers it. Those ports accept a command byte, set or clear a channel's software request, mask one channel or all of them, load a per-channel mode byte, clear the byte pointer that alternates low and high byte accesses, and reset the whole controller. The block keeps the status register, the mask, the command byte, the mode bytes and the byte pointer. From the mask and the pending requests it produces a registered vector of channels that are eligible for service.

The neighbouring channel datapath drives three inputs. One reports a terminal count. One toggles the byte pointer on each channel-register access. External request hold and release lines come from peripherals. Address and count arithmetic and the memory transfers stay outside.

Top module: `dma_ctl_top`

## Requirements
- R1: After reset every mask bit is 1, status, command, byte pointer, every mode byte and the eligible vector are 0.
- R2: A write to port 8 loads the command only when the data is 0x00 or 0x04. Any other value is dropped and leaves the command unchanged.
- R3: A write to port 9 sets request bit ch (status bit 4+ch, ch = data[1:0]) when data bit 2 is 1 and clears it when bit 2 is 0. In both cases it clears terminal-count bit ch (status bit ch).
- R4: A write to port 10 sets mask bit data[1:0] when data bit 2 is 1 and clears it otherwise. Other mask bits keep their value.
- R5: A write to port 11 stores the whole data byte as the mode of channel data[1:0]. That byte appears on mode_flat bits [8*ch+7:8*ch], with [7:6] transfer mode, 5 decrement, 4 auto-init, [3:2] operation and [1:0] channel.
- R6: ptr_toggle inverts byte_ptr. A write to port 12 clears byte_ptr, and the clear wins over a toggle in the same cycle.
- R7: A write to port 13 clears the byte pointer, the status and the command and sets all mask bits. It wins over every other source in the same cycle.
- R8: A write to port 14 clears all mask bits. A write to port 15 loads the mask from data[3:0].
- R9: rd_data is 0 while rd_en is low. With rd_en high, port 8 gives the status byte {request nibble, terminal-count nibble} and port 15 gives {4'b0, mask}. Every other port gives 0. A status read clears the terminal-count nibble at the end of that cycle.
- R10: eligible bit ch goes to 1 one cycle after a cycle in which mask bit ch is 0 and request bit ch is 1, and to 0 otherwise. It is registered from the state before that cycle's updates.
- R11: req_hold sets and req_release clears request bits. Hold wins over release, and a port 9 write for a channel wins over both for that channel.
- R12: tc_pulse sets terminal-count bits. A pulse survives a status read in the same cycle, but a port 9 write for that channel clears the bit.
- R13: Writes to ports 0 to 7 change no state held by this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | 4 | Register port index for the write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_port | input | 4 | Register port index for the read |
| rd_data | output | 8 | Read data, combinational |
| req_hold | input | 4 | External request set, one per channel |
| req_release | input | 4 | External request clear, one per channel |
| tc_pulse | input | 4 | Terminal count report, one per channel |
| ptr_toggle | input | 1 | Toggle the byte pointer |
| byte_ptr | output | 1 | Byte pointer: 0 low byte, 1 high byte |
| command | output | 8 | Command byte |
| mask | output | 4 | Channel mask, 1 = masked |
| mode_flat | output | 32 | Mode bytes of all channels, channel 0 lowest |
| eligible | output | 4 | Registered service-eligible vector |

## Verification
The in-design properties assume that a write and a read arrive as at most one strobe each per cycle, with port indices that are always driven. They also assume that the side inputs may be set on any cycle, including the cycle of a conflicting port write. The stimulus never leaves strobes or indices undriven. It deliberately lines up hold with release, terminal-count pulses with status reads and port 9 writes, and toggles with pointer clears, so the precedence rules are exercised inside those assumptions. Master reset writes appear in the random stream only occasionally, so that state has time to build up between them.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned PORT_W = 4;
    localparam logic [DATA_W-1:0] CMD_ALLOWED = 8'h04;

    typedef enum logic [PORT_W-1:0] {
        PORT_CMD   = 4'd8,
        PORT_REQ   = 4'd9,
        PORT_SMASK = 4'd10,
        PORT_MODE  = 4'd11,
        PORT_FFCLR = 4'd12,
        PORT_MRST  = 4'd13,
        PORT_MCLR  = 4'd14,
        PORT_MALL  = 4'd15
    } ctl_port_e;

    typedef struct packed {
        logic cmd;
        logic req;
        logic smask;
        logic mode;
        logic ffclr;
        logic mrst;
        logic mclr;
        logic mall;
    } wr_strobe_t;

    typedef struct packed {
        logic [1:0] xfer_mode;
        logic       down;
        logic       auto_init;
        logic [1:0] op;
        logic [1:0] chan;
    } mode_t;

    function automatic logic cmd_accept(input logic [DATA_W-1:0] d);
        return (d == '0) || (d == CMD_ALLOWED);
    endfunction

endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
    import dma_ctl_pkg::*;
(
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_port,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] rd_port,
    output wr_strobe_t        wr_s,
    output logic              rd_status,
    output logic              rd_mask
);
    always_comb begin
        wr_s = '0;
        if (wr_en) begin
            case (ctl_port_e'(wr_port))
                PORT_CMD:   wr_s.cmd   = 1'b1;
                PORT_REQ:   wr_s.req   = 1'b1;
                PORT_SMASK: wr_s.smask = 1'b1;
                PORT_MODE:  wr_s.mode  = 1'b1;
                PORT_FFCLR: wr_s.ffclr = 1'b1;
                PORT_MRST:  wr_s.mrst  = 1'b1;
                PORT_MCLR:  wr_s.mclr  = 1'b1;
                PORT_MALL:  wr_s.mall  = 1'b1;
                default:    wr_s = '0;
            endcase
        end
    end

    assign rd_status = rd_en && (rd_port == PORT_CMD);
    assign rd_mask   = rd_en && (rd_port == PORT_MALL);
endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status #(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_wr,
    input  logic              req_set,
    input  logic [CH_W-1:0]   req_ch,
    input  logic              mrst,
    input  logic              rd_clr,
    input  logic [NUM_CH-1:0] hold,
    input  logic [NUM_CH-1:0] release_i,
    input  logic [NUM_CH-1:0] tc_pulse,
    output logic [NUM_CH-1:0] req_q,
    output logic [NUM_CH-1:0] tc_q
);
    logic [NUM_CH-1:0] req_d, tc_d;

    always_comb begin
        req_d = (req_q & ~release_i) | hold;
        tc_d  = (rd_clr ? '0 : tc_q) | tc_pulse;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req_wr && (req_ch == CH_W'(i))) begin
                req_d[i] = req_set;
                tc_d[i]  = 1'b0;
            end
        end
        if (mrst) begin
            req_d = '0;
            tc_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            tc_q  <= '0;
        end else begin
            req_q <= req_d;
            tc_q  <= tc_d;
        end
    end

    // R7
    mrst_clears_status_chk: assert property (@(posedge clk) disable iff (rst)
        mrst |=> (req_q == '0) && (tc_q == '0));
    // R11
    hold_sets_req_chk: assert property (@(posedge clk) disable iff (rst)
        (hold != '0 && !mrst && !req_wr) |=> ((req_q & $past(hold)) == $past(hold)));
    // R12
    tc_survives_read_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse != '0 && !mrst && !req_wr) |=> ((tc_q & $past(tc_pulse)) == $past(tc_pulse)));
    // R3
    req_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_wr && !mrst) |=> (req_q[$past(req_ch)] == $past(req_set)) && !tc_q[$past(req_ch)]);
endmodule

// File: rtl/dma_ctl_maskmode.sv
module dma_ctl_maskmode
    import dma_ctl_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_strobe_t          wr_s,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                ptr_toggle,
    output logic [NUM_CH-1:0]   mask_q,
    output logic [DATA_W-1:0]   cmd_q,
    output logic                ptr_q,
    output logic [NUM_CH*DATA_W-1:0] mode_flat
);
    logic [CH_W-1:0] ch;
    mode_t           mode_q [NUM_CH];

    assign ch = wr_data[CH_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || wr_s.mrst) begin
            mask_q <= '1;
            cmd_q  <= '0;
            ptr_q  <= 1'b0;
        end else begin
            if (wr_s.ffclr)      ptr_q <= 1'b0;
            else if (ptr_toggle) ptr_q <= ~ptr_q;
            if (wr_s.cmd && cmd_accept(wr_data)) cmd_q <= wr_data;
            if (wr_s.smask)     mask_q[ch] <= wr_data[2];
            else if (wr_s.mclr) mask_q <= '0;
            else if (wr_s.mall) mask_q <= wr_data[NUM_CH-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_mode
        always_ff @(posedge clk) begin
            if (rst)
                mode_q[g] <= '0;
            else if (wr_s.mode && (ch == CH_W'(g)))
                mode_q[g] <= mode_t'(wr_data);
        end
        assign mode_flat[g*DATA_W +: DATA_W] = mode_q[g];
    end

    // R2
    cmd_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == '0) || (cmd_q == CMD_ALLOWED));
    // R8
    mask_clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        wr_s.mclr |=> (mask_q == '0));
    // R4
    single_mask_chk: assert property (@(posedge clk) disable iff (rst)
        wr_s.smask |=> (mask_q[$past(ch)] == $past(wr_data[2])));
    // R6
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_s.ffclr || wr_s.mrst) |=> !ptr_q);
endmodule

// File: rtl/dma_ctl_top.sv
module dma_ctl_top
    import dma_ctl_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [PORT_W-1:0]        wr_port,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en,
    input  logic [PORT_W-1:0]        rd_port,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [NUM_CH-1:0]        req_hold,
    input  logic [NUM_CH-1:0]        req_release,
    input  logic [NUM_CH-1:0]        tc_pulse,
    input  logic                     ptr_toggle,
    output logic                     byte_ptr,
    output logic [DATA_W-1:0]        command,
    output logic [NUM_CH-1:0]        mask,
    output logic [NUM_CH*DATA_W-1:0] mode_flat,
    output logic [NUM_CH-1:0]        eligible
);
    localparam int unsigned REQ_LSB = DATA_W / 2;

    wr_strobe_t        wr_s;
    logic              rd_status, rd_mask;
    logic [NUM_CH-1:0] req_q, tc_q, elig_q;

    dma_ctl_decode u_dec (
        .wr_en(wr_en), .wr_port(wr_port), .rd_en(rd_en), .rd_port(rd_port),
        .wr_s(wr_s), .rd_status(rd_status), .rd_mask(rd_mask)
    );

    dma_ctl_status #(.NUM_CH(NUM_CH)) u_stat (
        .clk(clk), .rst(rst),
        .req_wr(wr_s.req), .req_set(wr_data[2]), .req_ch(wr_data[CH_W-1:0]),
        .mrst(wr_s.mrst), .rd_clr(rd_status),
        .hold(req_hold), .release_i(req_release), .tc_pulse(tc_pulse),
        .req_q(req_q), .tc_q(tc_q)
    );

    dma_ctl_maskmode #(.NUM_CH(NUM_CH)) u_mm (
        .clk(clk), .rst(rst), .wr_s(wr_s), .wr_data(wr_data),
        .ptr_toggle(ptr_toggle), .mask_q(mask), .cmd_q(command),
        .ptr_q(byte_ptr), .mode_flat(mode_flat)
    );

    always_ff @(posedge clk) begin
        if (rst) elig_q <= '0;
        else     elig_q <= ~mask & req_q;
    end
    assign eligible = elig_q;

    always_comb begin
        rd_data = '0;
        if (rd_status) begin
            rd_data[NUM_CH-1:0]        = tc_q;
            rd_data[REQ_LSB +: NUM_CH] = req_q;
        end else if (rd_mask) begin
            rd_data[NUM_CH-1:0] = mask;
        end
    end

    // R10
    elig_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((eligible & $past(mask)) == '0) && ((eligible & ~$past(req_q)) == '0));
    // R9
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));
endmodule

// File: tb/tb_dma_ctl_top.sv
`timescale 1ns/1ps
module tb_dma_ctl_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, rd_en = 0, ptr_toggle = 0;
    logic [3:0] wr_port = 0, rd_port = 0, req_hold = 0, req_release = 0, tc_pulse = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data, command;
    logic byte_ptr;
    logic [3:0] mask, eligible;
    logic [31:0] mode_flat;

    always #2 clk = ~clk;

    dma_ctl_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
        .rd_en(rd_en), .rd_port(rd_port), .rd_data(rd_data),
        .req_hold(req_hold), .req_release(req_release), .tc_pulse(tc_pulse),
        .ptr_toggle(ptr_toggle), .byte_ptr(byte_ptr), .command(command),
        .mask(mask), .mode_flat(mode_flat), .eligible(eligible)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    string tag = "R1";

    // behavioural reference state
    int m_mask, m_req, m_tc, m_cmd, m_ptr, m_elig;
    int m_mode[4];

    task automatic chk(string t, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s phase %s actual %0h expected %0h", t, tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mask = 15; m_req = 0; m_tc = 0; m_cmd = 0; m_ptr = 0; m_elig = 0;
        foreach (m_mode[i]) m_mode[i] = 0;
    endtask

    task automatic model_step();
        int nreq, ntc, ch;
        m_elig = (~m_mask & m_req) & 15;
        nreq = (m_req & ~int'(req_release)) | int'(req_hold);
        ntc = (rd_en && rd_port == 8) ? 0 : m_tc;
        ntc |= int'(tc_pulse);
        if (ptr_toggle) m_ptr = m_ptr ^ 1;
        ch = int'(wr_data) & 3;
        if (wr_en) begin
            case (int'(wr_port))
                8:  if (wr_data == 0 || wr_data == 8'h04) m_cmd = int'(wr_data);
                9:  begin
                        if (wr_data[2]) nreq |= (1 << ch); else nreq &= ~(1 << ch);
                        ntc &= ~(1 << ch);
                    end
                10: if (wr_data[2]) m_mask |= (1 << ch); else m_mask &= ~(1 << ch);
                11: m_mode[ch] = int'(wr_data);
                12: m_ptr = 0;
                13: begin m_ptr = 0; m_mask = 15; m_cmd = 0; nreq = 0; ntc = 0; end
                14: m_mask = 0;
                15: m_mask = int'(wr_data) & 15;
                default: ;
            endcase
        end
        m_req = nreq & 15;
        m_tc = ntc & 15;
    endtask

    task automatic compare_all();
        chk("R10", int'(eligible), m_elig);
        chk("R4", int'(mask), m_mask);
        chk("R2", int'(command), m_cmd);
        chk("R6", int'(byte_ptr), m_ptr);
        for (int i = 0; i < 4; i++) chk("R5", int'(mode_flat[i*8 +: 8]), m_mode[i]);
    endtask

    // one clock: inputs driven just after a negedge, rd_data checked before the edge
    task automatic step(bit w, int p, int d, bit r, int rp, int h, int rl, int tc, bit tg);
        int exp_rd;
        wr_en = w; wr_port = 4'(p); wr_data = 8'(d);
        rd_en = r; rd_port = 4'(rp);
        req_hold = 4'(h); req_release = 4'(rl); tc_pulse = 4'(tc); ptr_toggle = tg;
        #1;
        exp_rd = 0;
        if (r && rp == 8) exp_rd = (m_req << 4) | m_tc;
        else if (r && rp == 15) exp_rd = m_mask;
        chk("R9", int'(rd_data), exp_rd);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int p, int d);
        step(1, p, d, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog phase %s actual hung expected finish", tag);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset values
        tag = "R1";
        compare_all();
        step(0, 0, 0, 1, 8, 0, 0, 0, 0);
        step(0, 0, 0, 1, 15, 0, 0, 0, 0);

        tag = "R2";
        wr(8, 8'h04); wr(8, 8'h05); wr(8, 8'h10); wr(8, 8'h84); wr(8, 8'h00); wr(8, 8'h01);

        tag = "R3";
        wr(14, 0);
        wr(9, 8'h06); idle(); wr(9, 8'h05); idle(); wr(9, 8'h02); idle();
        step(0, 0, 0, 0, 0, 0, 0, 4'hF, 0);
        wr(9, 8'h03);
        step(0, 0, 0, 1, 8, 0, 0, 0, 0);

        tag = "R4";
        wr(10, 8'h05); wr(10, 8'h06); wr(10, 8'h01); idle();

        tag = "R5";
        wr(11, 8'hA4); wr(11, 8'h5B); wr(11, 8'hFF); wr(11, 8'h32);

        tag = "R6";
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 12, 0, 0, 0, 0, 0, 0, 1);

        tag = "R8";
        wr(15, 8'hFA); wr(14, 8'hFF); wr(15, 8'h03); idle();

        tag = "R11";
        step(0, 0, 0, 0, 0, 4'b0011, 4'b0011, 0, 0);
        step(0, 0, 0, 0, 0, 0, 4'b0001, 0, 0);
        step(1, 9, 8'h01, 0, 0, 4'b0010, 0, 0, 0);
        step(1, 9, 8'h06, 0, 0, 0, 4'b0100, 0, 0);
        idle();

        tag = "R12";
        step(0, 0, 0, 1, 8, 0, 0, 4'b1000, 0);
        step(0, 0, 0, 1, 8, 0, 0, 0, 0);
        step(1, 9, 8'h04, 0, 0, 0, 0, 4'b0001, 0);
        step(0, 0, 0, 1, 8, 0, 0, 0, 0);

        tag = "R13";
        wr(8, 8'h04); wr(11, 8'h11);
        for (int p = 0; p < 8; p++) wr(p, 8'hFF);
        step(0, 0, 0, 1, 8, 0, 0, 0, 0);
        step(0, 0, 0, 1, 3, 0, 0, 0, 0);

        tag = "R7";
        step(0, 0, 0, 0, 0, 4'hF, 0, 4'hF, 1);
        step(1, 13, 0, 1, 8, 4'hF, 0, 4'hF, 1);
        idle();
        step(0, 0, 0, 1, 8, 0, 0, 0, 0);

        tag = "R10";
        for (int n = 0; n < 600; n++) begin
            int p;
            p = (($urandom % 40) == 0) ? 13 : int'($urandom % 16);
            if (p == 13 && ($urandom % 2) == 0) p = 9;
            step(($urandom % 3) != 0, p, int'($urandom % 256),
                 ($urandom % 2) == 0, int'($urandom % 16),
                 int'($urandom % 16) & int'($urandom % 16),
                 int'($urandom % 16) & int'($urandom % 16),
                 int'($urandom % 16) & int'($urandom % 16),
                 ($urandom % 2) == 0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule